// File: doc/BRIEF.md
# Remote-Control Serial Code Word Decoder

This block turns a pulse-width-coded serial line into a validated command. Code words are sent as 12 symbols, each a pair of sub-pulses, and consecutive words are separated by a long low gap. The first `ADDR_W` symbols of a word form the address. Each of them is compared with a local three-state setting (zero, one or floating). The remaining `12-ADDR_W` symbols carry data bits.

A word changes the outputs only when two error-free words in a row match the local address and carry the same data. When that happens, the valid flag rises and the data outputs take the word's data. The flag falls on any bad word, on a word with new data, on a word cut short by a gap, or when the line stays low long enough to count as no signal. The data outputs keep the last accepted value until another transmission is accepted.

The serial line is a single wire that cannot be stalled, so it has no valid/ready handshake. The flag and the data are plain level outputs. The serial input is taken to be synchronous to `clk` already.

Top module: `rcd_decoder`

## Requirements
- R1: Synchronous reset (`rst` high) drives `vt` low and `data_out` to zero.
- R2: A sub-pulse lasts `SUB_TICKS` clocks. It is short when high for about a third of that period and long when high for about two thirds; pulses high for fewer than `SUB_TICKS/2` clocks count as short. A symbol is two sub-pulses: short,short is 0; long,long is 1; short,long is floating; long,short is an illegal symbol.
- R3: A word begins only after `din` has been low for at least `4*2*SUB_TICKS` clocks. Address symbol k (k < `ADDR_W`) must equal `addr_cfg[2k+1:2k]`, coded 00 = 0, 01 = 1, 10 = floating.
- R4: Symbol position `ADDR_W+i` supplies `data_out[i]`. A data symbol must be 0 or 1.
- R5: A word with an address mismatch, an illegal symbol or a floating data symbol drives `vt` low at the end of that word, and the confirmation sequence restarts.
- R6: Two consecutive good words with equal data raise `vt` and load `data_out`. Further identical good words keep `vt` high.
- R7: A good word whose data differs from the previous good word drives `vt` low and leaves `data_out` unchanged. It becomes the new candidate, so one more identical word is accepted.
- R8: A word that is incomplete when a gap begins is discarded, `vt` goes low, and the confirmation sequence restarts.
- R9: When `din` stays low for `IDLE_SYMS*2*SUB_TICKS` clocks, `vt` goes low (standby).
- R10: `data_out` holds its last accepted value while `vt` is low.
- R11: Pulses that arrive before any gap has been seen since reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial code line |
| addr_cfg | input | 2*ADDR_W | Local three-state address, 2 bits per position |
| vt | output | 1 | Valid transmission flag |
| data_out | output | max(1,12-ADDR_W) | Latched data bits |

## Verification
Two things can happen in the same clock: `vt` can fall while the data latch holds its old value. This occurs when a good word arrives with data different from the accepted value. The bench provokes it directly, and also through random streams that repeat data only part of the time. It then checks that `vt` drops after the first differing word while `data_out` keeps the old value, and that the second identical word raises `vt` with the new data. The bench also checks that a partial word cut by a gap and a long idle period both clear `vt` without touching the latched data.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  localparam int WORD_SYMS = 12;
  typedef enum logic [1:0] {
    SYM_ZERO  = 2'b00,
    SYM_ONE   = 2'b01,
    SYM_FLOAT = 2'b10,
    SYM_BAD   = 2'b11
  } sym_e;
endpackage

// File: rtl/rcd_pulse_demod.sv
module rcd_pulse_demod #(
  parameter int SUB_TICKS = 12,
  parameter int GAP_SYMS  = 4,
  parameter int IDLE_SYMS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  output logic          sym_valid,
  output rcd_pkg::sym_e sym,
  output logic          gap,
  output logic          idle
);
  import rcd_pkg::*;
  localparam int HALF       = SUB_TICKS / 2;
  localparam int GAP_TICKS  = GAP_SYMS * 2 * SUB_TICKS;
  localparam int IDLE_TICKS = IDLE_SYMS * 2 * SUB_TICKS;
  localparam int CW         = $clog2(IDLE_TICKS + 1);

  logic          din_q, have_first, first_long, is_long;
  logic [CW-1:0] hi_cnt, lo_cnt;
  sym_e          sym_q, sym_nxt;
  logic          sym_valid_q, gap_q, idle_q;

  // hi_cnt holds the previous high clocks; the current one makes it +1
  assign is_long = hi_cnt >= CW'(HALF - 1);

  always_comb begin
    case ({first_long, is_long})
      2'b00:   sym_nxt = SYM_ZERO;
      2'b11:   sym_nxt = SYM_ONE;
      2'b01:   sym_nxt = SYM_FLOAT;
      default: sym_nxt = SYM_BAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q <= 1'b0; have_first <= 1'b0; first_long <= 1'b0;
      hi_cnt <= '0; lo_cnt <= '0; sym_q <= SYM_ZERO;
      sym_valid_q <= 1'b0; gap_q <= 1'b0; idle_q <= 1'b0;
    end else begin
      din_q <= din;
      sym_valid_q <= 1'b0;
      gap_q <= 1'b0;
      idle_q <= 1'b0;
      if (din_q) begin
        lo_cnt <= '0;
        if (hi_cnt != {CW{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != CW'(IDLE_TICKS)) lo_cnt <= lo_cnt + 1'b1;
        if (lo_cnt == CW'(GAP_TICKS - 1)) begin
          gap_q <= 1'b1;
          have_first <= 1'b0;
        end
        if (lo_cnt == CW'(IDLE_TICKS - 1)) idle_q <= 1'b1;
      end
      if (din_q && !din) begin
        if (!have_first) begin
          have_first <= 1'b1;
          first_long <= is_long;
        end else begin
          have_first <= 1'b0;
          sym_valid_q <= 1'b1;
          sym_q <= sym_nxt;
        end
      end
    end
  end

  assign sym_valid = sym_valid_q;
  assign sym       = sym_q;
  assign gap       = gap_q;
  assign idle      = idle_q;

  assert_sym_gap_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(sym_valid_q && gap_q));
  assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
    idle_q |-> !din_q);
endmodule

// File: rtl/rcd_word_asm.sv
module rcd_word_asm #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  parameter int DP     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_valid,
  input  rcd_pkg::sym_e     sym,
  input  logic              gap,
  input  logic [2*ADDR_W-1:0] addr_cfg,
  output logic              word_done,
  output logic              word_ok,
  output logic [DP-1:0]     word_data,
  output logic              word_abort
);
  import rcd_pkg::*;
  localparam logic [3:0] LAST = 4'(WORD_SYMS - 1);

  logic          armed, bad, done_q, ok_q, abort_q;
  logic [3:0]    cnt;
  logic [DP-1:0] acc, acc_nxt, wdata_q;
  logic [1:0]    cfg_sym;
  logic          sym_err;

  always_comb begin
    cfg_sym = 2'b11;
    for (int k = 0; k < ADDR_W; k++)
      if (cnt == 4'(k)) cfg_sym = addr_cfg[2*k +: 2];
    acc_nxt = acc;
    for (int i = 0; i < DATA_W; i++)
      if (cnt == 4'(ADDR_W + i)) acc_nxt[i] = (sym == SYM_ONE);
    if (sym == SYM_BAD)              sym_err = 1'b1;
    else if (cnt < 4'(ADDR_W))       sym_err = (sym != sym_e'(cfg_sym));
    else                             sym_err = (sym == SYM_FLOAT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0; bad <= 1'b0; cnt <= '0; acc <= '0;
      done_q <= 1'b0; ok_q <= 1'b0; abort_q <= 1'b0; wdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      abort_q <= 1'b0;
      if (gap) begin
        armed <= 1'b1;
        cnt <= '0;
        bad <= 1'b0;
        if (cnt != '0) abort_q <= 1'b1;
      end else if (sym_valid && armed) begin
        acc <= acc_nxt;
        if (cnt == LAST) begin
          done_q <= 1'b1;
          ok_q <= !(bad || sym_err);
          wdata_q <= acc_nxt;
          armed <= 1'b0;
          cnt <= '0;
          bad <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
          bad <= bad | sym_err;
        end
      end
    end
  end

  assign word_done  = done_q;
  assign word_ok    = ok_q;
  assign word_data  = wdata_q;
  assign word_abort = abort_q;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_done_abort_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(done_q && abort_q));
endmodule

// File: rtl/rcd_confirm.sv
module rcd_confirm #(
  parameter int DP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_done,
  input  logic          word_ok,
  input  logic [DP-1:0] word_data,
  input  logic          word_abort,
  input  logic          idle,
  output logic          vt,
  output logic [DP-1:0] data_out
);
  logic          vt_q, prev_ok;
  logic [DP-1:0] prev_data, dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vt_q <= 1'b0; prev_ok <= 1'b0; prev_data <= '0; dout_q <= '0;
    end else if (word_abort || idle) begin
      vt_q <= 1'b0;
      prev_ok <= 1'b0;
    end else if (word_done) begin
      if (!word_ok) begin
        vt_q <= 1'b0;
        prev_ok <= 1'b0;
      end else if (prev_ok && prev_data == word_data) begin
        vt_q <= 1'b1;
        dout_q <= word_data;
      end else begin
        vt_q <= 1'b0;
        prev_ok <= 1'b1;
        prev_data <= word_data;
      end
    end
  end

  assign vt       = vt_q;
  assign data_out = dout_q;

  assert_vt_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(vt_q) |-> $past(word_done && word_ok));
  assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout_q) |-> vt_q);
  assert_idle_drop_R9: assert property (@(posedge clk) disable iff (rst)
    idle |=> !vt_q);
  assert_bad_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (word_done && !word_ok) |=> !vt_q);
  assert_abort_drop_R8: assert property (@(posedge clk) disable iff (rst)
    word_abort |=> !vt_q);
endmodule

// File: rtl/rcd_decoder.sv
module rcd_decoder #(
  parameter int ADDR_W    = 8,
  parameter int SUB_TICKS = 12,
  parameter int GAP_SYMS  = 4,
  parameter int IDLE_SYMS = 16,
  localparam int DATA_W   = rcd_pkg::WORD_SYMS - ADDR_W,
  localparam int DP       = (DATA_W > 0) ? DATA_W : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                din,
  input  logic [2*ADDR_W-1:0] addr_cfg,
  output logic                vt,
  output logic [DP-1:0]       data_out
);
  logic          sym_valid, gap, idle;
  rcd_pkg::sym_e sym;
  logic          word_done, word_ok, word_abort;
  logic [DP-1:0] word_data;

  rcd_pulse_demod #(.SUB_TICKS(SUB_TICKS), .GAP_SYMS(GAP_SYMS), .IDLE_SYMS(IDLE_SYMS)) u_demod (
    .clk(clk), .rst(rst), .din(din),
    .sym_valid(sym_valid), .sym(sym), .gap(gap), .idle(idle));

  rcd_word_asm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DP(DP)) u_asm (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym(sym), .gap(gap),
    .addr_cfg(addr_cfg), .word_done(word_done), .word_ok(word_ok),
    .word_data(word_data), .word_abort(word_abort));

  rcd_confirm #(.DP(DP)) u_confirm (
    .clk(clk), .rst(rst), .word_done(word_done), .word_ok(word_ok),
    .word_data(word_data), .word_abort(word_abort), .idle(idle),
    .vt(vt), .data_out(data_out));
endmodule

// File: tb/tb_rcd_decoder.sv
`timescale 1ns/1ps
module tb_rcd_decoder;
  localparam int ADDR_W = 8;
  localparam int SUBT   = 12;
  localparam int SYMT   = 2 * SUBT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        din = 1'b0;
  logic [15:0] addr_cfg;
  logic        vt;
  logic [3:0]  data_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state
  logic       m_vt = 1'b0;
  logic [3:0] m_data = '0;
  logic       m_prev_ok = 1'b0;
  logic [3:0] m_prev = '0;

  always #2 clk = ~clk;

  rcd_decoder #(.ADDR_W(ADDR_W), .SUB_TICKS(SUBT)) dut (
    .clk(clk), .rst(rst), .din(din), .addr_cfg(addr_cfg),
    .vt(vt), .data_out(data_out));

  // local address: F,1,0,1,F,0,0,1 (00=0, 01=1, 10=float)
  function automatic logic [15:0] mk_cfg();
    logic [1:0] c [8] = '{2'b10, 2'b01, 2'b00, 2'b01, 2'b10, 2'b00, 2'b00, 2'b01};
    logic [15:0] r;
    for (int k = 0; k < 8; k++) r[2*k +: 2] = c[k];
    return r;
  endfunction

  function automatic logic [23:0] mk_word(input logic [3:0] d);
    logic [23:0] w;
    w[15:0] = mk_cfg();
    for (int i = 0; i < 4; i++) w[16 + 2*i +: 2] = {1'b0, d[i]};
    return w;
  endfunction

  function automatic bit word_good(input logic [23:0] w);
    bit g = 1;
    for (int k = 0; k < 8; k++) if (w[2*k +: 2] != addr_cfg[2*k +: 2]) g = 0;
    for (int i = 0; i < 4; i++) if (w[16 + 2*i + 1]) g = 0;
    return g;
  endfunction

  function automatic logic [3:0] word_dat(input logic [23:0] w);
    logic [3:0] d;
    for (int i = 0; i < 4; i++) d[i] = w[16 + 2*i];
    return d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sub(input bit lng);
    int h = lng ? (2*SUBT)/3 : SUBT/3;
    for (int t = 0; t < SUBT; t++) begin
      @(negedge clk);
      din = (t < h);
    end
  endtask

  task automatic send_sym(input logic [1:0] c);
    case (c)
      2'b00: begin sub(0); sub(0); end
      2'b01: begin sub(1); sub(1); end
      2'b10: begin sub(0); sub(1); end
      default: begin sub(1); sub(0); end
    endcase
  endtask

  task automatic low(input int syms);
    for (int t = 0; t < syms * SYMT; t++) begin
      @(negedge clk);
      din = 1'b0;
    end
  endtask

  task automatic send_word(input logic [23:0] w);
    for (int k = 0; k < 12; k++) send_sym(w[2*k +: 2]);
  endtask

  task automatic model_word(input logic [23:0] w);
    if (!word_good(w)) begin
      m_vt = 0; m_prev_ok = 0;
    end else if (m_prev_ok && m_prev == word_dat(w)) begin
      m_vt = 1; m_data = word_dat(w);
    end else begin
      m_vt = 0; m_prev_ok = 1; m_prev = word_dat(w);
    end
  endtask

  task automatic word_chk(input logic [23:0] w, input string req);
    send_word(w);
    low(5);
    model_word(w);
    check({req, " vt"}, 32'(vt), 32'(m_vt));
    check({req, " data"}, 32'(data_out), 32'(m_data));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    logic [3:0] d;
    void'($urandom(32'd4242));
    addr_cfg = mk_cfg();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 vt reset", 32'(vt), 0);
    check("R1 data reset", 32'(data_out), 0);

    // R11: good word before any gap is ignored
    send_word(mk_word(4'hA));
    low(5);
    check("R11 unarmed word", 32'(vt), 0);
    word_chk(mk_word(4'hA), "R11 first after gap");
    word_chk(mk_word(4'hA), "R6 R2 R3 accept");
    check("R4 data map", 32'(data_out), 32'hA);
    word_chk(mk_word(4'hA), "R6 repeat");

    // R7: new data, vt falls while data holds
    word_chk(mk_word(4'h5), "R7 new data");
    check("R7 R10 hold", 32'(data_out), 32'hA);
    word_chk(mk_word(4'h5), "R7 confirm");

    // R8: partial word
    for (int k = 0; k < 5; k++) send_sym(mk_word(4'h5)[2*k +: 2]);
    low(5);
    m_vt = 0; m_prev_ok = 0;
    check("R8 partial vt", 32'(vt), 0);
    check("R8 R10 partial data", 32'(data_out), 32'h5);
    word_chk(mk_word(4'h5), "R8 restart");
    word_chk(mk_word(4'h5), "R8 reaccept");

    // R9: idle
    low(20);
    m_vt = 0; m_prev_ok = 0;
    check("R9 idle vt", 32'(vt), 0);
    check("R9 R10 idle data", 32'(data_out), 32'h5);

    // R5: address mismatch (float expected at pos0, send 0)
    word_chk(mk_word(4'h3), "R5 pre");
    w = mk_word(4'h3); w[1:0] = 2'b00;
    word_chk(w, "R5 R3 addr mismatch");
    word_chk(mk_word(4'h3), "R5 restart");
    word_chk(mk_word(4'h3), "R5 accept");
    w = mk_word(4'h3); w[19:18] = 2'b11;
    word_chk(w, "R5 R2 illegal sym");
    w = mk_word(4'h3); w[17:16] = 2'b10;
    word_chk(w, "R5 R4 float data");
    check("R10 after errors", 32'(data_out), 32'h3);

    // random stream
    d = 4'h3;
    for (int n = 0; n < 70; n++) begin
      int r = int'($urandom_range(0, 15));
      if (r >= 6) d = 4'($urandom_range(0, 15));
      w = mk_word(d);
      if (r == 0) w[2*($urandom_range(0, 7)) +: 2] ^= 2'b01;
      if (r == 1) w[2*($urandom_range(0, 11)) +: 2] = 2'b11;
      word_chk(w, "R6 R7 R5 random");
      if (r == 2) word_chk(w, "R6 random repeat");
      if (r == 3) begin
        low(20);
        m_vt = 0; m_prev_ok = 0;
        check("R9 random idle", 32'(vt), 0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule